// File: doc/BRIEF.md
# Ethernet Transmit Framer with Pad and FCS Insertion

This block sits in the 10 Mb/s transmit path, between a byte-wide frame source and a byte-wide serializer that puts bit 0 of each byte on the wire first. When a frame is offered, the block first emits the preamble and the start-of-frame delimiter. It then passes the payload through, one byte per source handshake. If automatic padding is on and the frame is still shorter than 544 bits at that point (counting the preamble and delimiter), it adds zero bytes. Last, it appends the 32-bit CRC frame check sequence.

Two control inputs are sampled once at the start of each frame. Automatic padding always forces the FCS on. The FCS-disable control removes the FCS only when padding is off.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, tx_active_o, tx_valid_o and s_ready_o are all 0.
- R2: Every frame begins with seven bytes of 0x55 and then one byte of 0xD5. This gives 56 bits of alternating 1/0 followed by 10101011 on the wire. tx_valid_o is high for each of these bytes.
- R3: In the payload phase, s_ready_o is 1. tx_valid_o equals s_valid_i and tx_data_o equals s_data_i, so a source stall produces a gap. In every other phase s_ready_o is 0.
- R4: With auto-pad on, suppose the byte count after the last payload byte (preamble and delimiter included) is below 68 bytes (544 bits). Then 0x00 bytes follow until 68 bytes have gone out. A minimum padded frame is therefore 72 bytes (576 bits) including the FCS.
- R5: No pad is added when auto-pad is off, or when the frame already holds at least 68 bytes at the end of the payload. A payload of 60 bytes reaches 68 exactly and gets no pad.
- R6: The FCS is four bytes of CRC-32. It uses polynomial 0x04C11DB7, is preset to all ones, covers the payload and pad bytes only, and is complemented before it is sent. The CRC is computed bit-reflected, and its complement goes out lowest byte first. This sends the x^31 coefficient first. For the payload "123456789" the bytes are 0x26, 0x39, 0xF4, 0xCB.
- R7: With FCS-disable set and auto-pad off, the frame ends right after the last payload byte.
- R8: With auto-pad on, the FCS is appended even when FCS-disable is set.
- R9: auto_pad_i and fcs_dis_i are sampled in the cycle the frame starts. Changing them later in the frame has no effect on that frame.
- R10: tx_active_o stays high from the first preamble byte to the last byte of the frame, including cycles when the source stalls. It then drops for at least one cycle before the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | 8 | Payload byte from the source |
| s_valid_i | input | 1 | Source byte valid |
| s_last_i | input | 1 | Marks the final payload byte |
| s_ready_o | output | 1 | Block accepts a payload byte |
| auto_pad_i | input | 1 | Pad short frames to the minimum (forces FCS) |
| fcs_dis_i | input | 1 | Suppress the FCS when auto-pad is off |
| tx_data_o | output | 8 | Byte to the serializer |
| tx_valid_o | output | 1 | tx_data_o holds a frame byte this cycle |
| tx_active_o | output | 1 | A frame is in progress |

## Verification
A byte counter that is off by one shows up as a frame one byte too long or too short, visible at the pad/FCS boundary of the first short frame. A wrong CRC register or a wrong byte order corrupts all four FCS bytes of the very next frame that carries them. A phase decoder that asserts ready at the wrong time lets payload bytes overwrite preamble or pad bytes in the same cycle. Known-answer CRC frames, a frame exactly at the length threshold and a frame one byte below it expose these faults within one frame.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [7:0]  PAD_BYTE      = 8'h00;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q ^ {24'h0, data_i};
    for (int b = 0; b < 8; b++)
      crc_d = crc_d[0] ? ((crc_d >> 1) ^ CRC_POLY_REFL) : (crc_d >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_PRESET;
    else if (init_i) crc_q <= CRC_PRESET;
    else if (en_i)   crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R6: CRC register holds while no byte is folded in
  a_r6_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_o));
  a_r6_crc_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (crc_o == CRC_PRESET));
endmodule

// File: rtl/eth_tx_len.sv
module eth_tx_len #(
  parameter int CNT_W     = 12,
  parameter int MIN_BYTES = 68
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             short_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  // true when the byte now going out still leaves the frame below minimum
  assign short_o = ({1'b0, cnt_q} + 1'b1) < (CNT_W+1)'(MIN_BYTES);

  a_r4_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int MIN_BITS  = 544,
  parameter int CNT_W     = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       auto_pad_i,
  input  logic       fcs_dis_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  output logic       tx_active_o
);
  localparam int MIN_BYTES = MIN_BITS / 8;
  localparam int FCS_BYTES = 4;

  tx_state_e        state_q, state_d;
  logic             pad_en_q, fcs_en_q;
  logic [1:0]       fcs_idx_q;
  logic [CNT_W-1:0] cnt;
  logic             short_frm, beat;
  logic [31:0]      crc;
  logic [31:0]      fcs_word;

  assign s_ready_o   = (state_q == ST_DATA);
  assign beat        = s_ready_o & s_valid_i;
  assign tx_active_o = (state_q != ST_IDLE);
  assign fcs_word    = ~crc;

  eth_tx_len #(.CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .inc_i   (tx_valid_o),
    .cnt_o   (cnt),
    .short_o (short_frm)
  );

  eth_tx_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (state_q == ST_SFD),
    .en_i   (beat || state_q == ST_PAD),
    .data_i (tx_data_o),
    .crc_o  (crc)
  );

  always_comb begin
    tx_valid_o = 1'b1;
    tx_data_o  = PAD_BYTE;
    unique case (state_q)
      ST_IDLE: tx_valid_o = 1'b0;
      ST_PRE:  tx_data_o  = PRE_BYTE;
      ST_SFD:  tx_data_o  = SFD_BYTE;
      ST_DATA: begin
        tx_valid_o = s_valid_i;
        tx_data_o  = s_data_i;
      end
      ST_PAD:  tx_data_o = PAD_BYTE;
      ST_FCS: begin
        unique case (fcs_idx_q)
          2'd0: tx_data_o = fcs_word[7:0];
          2'd1: tx_data_o = fcs_word[15:8];
          2'd2: tx_data_o = fcs_word[23:16];
          default: tx_data_o = fcs_word[31:24];
        endcase
      end
      default: tx_valid_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (s_valid_i) state_d = ST_PRE;
      ST_PRE:  if (cnt == CNT_W'(PRE_BYTES - 1)) state_d = ST_SFD;
      ST_SFD:  state_d = ST_DATA;
      ST_DATA: if (beat && s_last_i) begin
        if (pad_en_q && short_frm) state_d = ST_PAD;
        else if (fcs_en_q)         state_d = ST_FCS;
        else                       state_d = ST_IDLE;
      end
      ST_PAD:  if (!short_frm) state_d = ST_FCS;
      ST_FCS:  if (fcs_idx_q == 2'(FCS_BYTES - 1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pad_en_q  <= 1'b0;
      fcs_en_q  <= 1'b1;
      fcs_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && s_valid_i) begin
        pad_en_q <= auto_pad_i;
        fcs_en_q <= auto_pad_i | ~fcs_dis_i; // pad forces FCS
      end
      if (state_q == ST_FCS) fcs_idx_q <= fcs_idx_q + 1'b1;
      else                   fcs_idx_q <= '0;
    end
  end

  a_r2_sfd_follows_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SFD) |-> ($past(state_q) == ST_PRE));
  a_r3_ready_after_sfd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s_ready_o) |-> ($past(state_q) == ST_SFD));
  a_r4_pad_ends_at_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PAD && $past(state_q) == ST_PAD) |-> (cnt == CNT_W'(MIN_BYTES)));
  a_r6_fcs_four_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_FCS && $past(state_q) == ST_FCS) |-> ($past(fcs_idx_q) == 2'd3));
  a_r10_valid_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_active_o);
endmodule

// File: tb/eth_tx_framer_bench.sv
module eth_tx_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_BYTES  = 68;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0, s_last = 1'b0, auto_pad = 1'b0, fcs_dis = 1'b0;
  logic       s_ready, tx_valid, tx_active;
  logic [7:0] tx_data;

  int errors = 0, checks = 0;
  logic [7:0] pl  [0:127];
  logic [7:0] cap [0:255];
  logic [7:0] exp_b [0:255];
  int got_n, exp_n, ready_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_framer u_eth_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .s_data_i(s_data), .s_valid_i(s_valid),
    .s_last_i(s_last), .s_ready_o(s_ready), .auto_pad_i(auto_pad),
    .fcs_dis_i(fcs_dis), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_active_o(tx_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ exp_b[8+i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  // builds exp_b from the requirements: R2 header, R4/R5 pad, R6/R7/R8 FCS
  task automatic build_exp(input int n, input bit ap, input bit fd);
    logic [31:0] f;
    for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
    exp_b[7] = 8'hD5;
    for (int i = 0; i < n; i++) exp_b[8+i] = pl[i];
    exp_n = 8 + n;
    if (ap) while (exp_n < MIN_BYTES) begin exp_b[exp_n] = 8'h00; exp_n++; end
    if (ap || !fd) begin
      f = ref_crc(exp_n - 8);
      for (int k = 0; k < 4; k++) exp_b[exp_n + k] = f[8*k +: 8];
      exp_n += 4;
    end
  endtask

  task automatic run_frame(input int n, input bit ap, input bit fd,
                           input bit stall, input bit flip);
    int idx = 0, cyc = 0;
    bit seen = 0, acc;
    got_n = 0; ready_bad = 0;
    auto_pad = ap; fcs_dis = fd;
    s_valid = 1'b1; s_data = pl[0]; s_last = (n == 1);
    forever begin
      @(negedge clk);
      if (tx_active) seen = 1;
      else if (seen) break;
      if (s_ready && (got_n < 8 || idx >= n)) ready_bad++;
      if (tx_valid) begin cap[got_n] = tx_data; got_n++; end
      acc = s_ready && s_valid;
      @(posedge clk); #1;
      if (acc) begin
        idx++;
        if (flip) begin auto_pad = ~ap; fcs_dis = ~fd; end
      end
      if (idx < n) begin
        s_valid = stall ? (cyc % 3 != 0) : 1'b1;
        s_data = pl[idx]; s_last = (idx == n - 1);
      end else begin
        s_valid = 1'b0; s_last = 1'b0;
      end
      cyc++;
      if (cyc > 3000) begin chk(0, "R10 frame timeout", cyc, 0); break; end
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(got_n == exp_n, {req, " length"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
    chk(bad < 0, {req, " bytes"}, (bad < 0) ? 0 : cap[bad], (bad < 0) ? 0 : exp_b[bad]);
    chk(ready_bad == 0, "R3 ready outside payload", ready_bad, 0);
  endtask

  task automatic fill_seq(input int n, input int seed);
    for (int i = 0; i < n; i++) pl[i] = 8'((i * 37 + seed) & 8'hFF);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!tx_active && !tx_valid && !s_ready, "R1 reset idle",
        {tx_active, tx_valid, s_ready}, 0);
  endtask

  task automatic t_known_crc;
    string s = "123456789";
    for (int i = 0; i < 9; i++) pl[i] = s[i];
    run_frame(9, 0, 0, 0, 0);
    build_exp(9, 0, 0);
    compare("R2 R6 known crc");
    chk({cap[20], cap[19], cap[18], cap[17]} == 32'hCBF43926, "R6 fcs value",
        {cap[20], cap[19], cap[18], cap[17]}, 32'hCBF43926);
  endtask

  task automatic t_pad_short;
    fill_seq(10, 3);
    run_frame(10, 1, 0, 0, 0);
    build_exp(10, 1, 0);
    compare("R4 pad short");
    chk(got_n == 72, "R4 min frame 576 bits", got_n * 8, 576);
  endtask

  task automatic t_pad_forces_fcs;
    fill_seq(5, 9);
    run_frame(5, 1, 1, 0, 0);
    build_exp(5, 1, 1);
    compare("R8 forced fcs");
  endtask

  task automatic t_no_fcs;
    fill_seq(12, 1);
    run_frame(12, 0, 1, 0, 0);
    build_exp(12, 0, 1);
    compare("R7 no fcs");
    chk(got_n == 20, "R5 no pad when off", got_n, 20);
  endtask

  task automatic t_long_and_edges;
    fill_seq(70, 5);
    run_frame(70, 1, 0, 0, 0);
    build_exp(70, 1, 0);
    compare("R5 long frame");
    fill_seq(60, 7);
    run_frame(60, 1, 0, 0, 0);
    build_exp(60, 1, 0);
    compare("R5 exact threshold");
    fill_seq(59, 8);
    run_frame(59, 1, 0, 0, 0);
    build_exp(59, 1, 0);
    compare("R4 one byte short");
    fill_seq(1, 200);
    run_frame(1, 1, 0, 0, 0);
    build_exp(1, 1, 0);
    compare("R4 single byte");
  endtask

  task automatic t_stall;
    fill_seq(20, 11);
    run_frame(20, 0, 0, 1, 0);
    build_exp(20, 0, 0);
    compare("R3 R10 stalled source");
    @(negedge clk);
    chk(!tx_active, "R10 idle gap", tx_active, 0);
  endtask

  task automatic t_ctrl_sampled;
    fill_seq(8, 21);
    run_frame(8, 1, 0, 0, 1);
    build_exp(8, 1, 0);
    compare("R9 controls sampled");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "R10 watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_known_crc();
    t_pad_short();
    t_pad_forces_fcs();
    t_no_fcs();
    t_long_and_edges();
    t_stall();
    t_ctrl_sampled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule